// File: doc/BRIEF.md
# Stereo PWM Sample Pacing Timer

The block paces playback of a stereo pulse-width stream. A host writes pulse-width samples into a small queue for each channel, one queue for the left channel and one for the right. A programmable period, counted in system clocks, sets the sample rate. At the end of each period the block moves one sample from each queue to the matching output register. If a queue is empty at that moment, the previous output value is kept.

Period ends are also counted down toward an interrupt. After a programmable number of periods (1 to 16), the block raises a level interrupt if no earlier interrupt is still waiting and at least one consumer has interrupts enabled. The interrupt stays high until it is acknowledged. A control bit can also make each raised interrupt emit a one-clock request to a DMA channel, so that the DMA channel refills the queues.

Registers are written through a plain write strobe with a 2-bit select. Select 0 is control, 1 is the period, 2 is the left sample queue and 3 is the right sample queue. Queue full and empty flags are visible on ports.

Top module: `pwm_pacer`

## Requirements
- R1: A period write (select 1) keeps only bits 11:0 of the data. With a period of P greater than 0, a sample boundary occurs every P clocks, counted from the period write. A period of 0 produces no boundaries, so no samples are consumed and no interrupt countdown takes place.
- R2: A sample write (select 2 for left, select 3 for right) stores (data - 1) masked to 12 bits. At each boundary, the oldest stored value of each non-empty queue appears on that channel's output one clock after the boundary edge.
- R3: If a queue is empty at a boundary, that channel's output keeps its previous value.
- R4: Each queue holds 3 entries. A write to a full queue is dropped. fifo_full_o and fifo_empty_o report the state of each queue, with bit 0 for left and bit 1 for right.
- R5: The interrupt countdown length N is control bits 11:8, where the value 0 means 16. When P > 0 and the control register was written while the period was 0, irq_o rises exactly N*P clocks after the period write.
- R6: A control write (select 0) restarts the countdown from the N of the newly written value.
- R7: irq_o stays high until irq_ack_i is sampled high. It is low on the clock after that.
- R8: A countdown that expires while irq_o is high, or while every bit of irq_en_i is low, raises nothing. The countdown then reloads and continues.
- R9: When control bit 7 is set, dreq_o is high for exactly the one clock in which irq_o first reads high. When bit 7 is clear, dreq_o stays low.
- R10: After reset, both outputs are 0, both queues are empty and not full, irq_o and dreq_o are low, the period is 0 and the countdown length is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1 period, 2 left queue, 3 right queue |
| wr_data_i | input | 16 | Write data |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_en_i | input | NUM_CONS | Per-consumer interrupt enables |
| sample_l_o | output | 12 | Current left pulse width |
| sample_r_o | output | 12 | Current right pulse width |
| fifo_full_o | output | 2 | Queue full flags (bit 0 left, bit 1 right) |
| fifo_empty_o | output | 2 | Queue empty flags (bit 0 left, bit 1 right) |
| irq_o | output | 1 | Interrupt request level |
| dreq_o | output | 1 | One-clock DMA request pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit period, 3-entry queues and two interrupt consumers. It sweeps the countdown field over 1, 2, 3 and 0, which covers the wrap to 16. Each of those settings is combined with periods 1, 2 and 3, and the DMA-request bit alternates between settings. This makes it possible to check the exact N*P arrival time of every interrupt and the pulse alignment at every point of the sweep. The queue depth of 3 is small enough that the bench can reach overflow, draining, and holding the last sample with a handful of writes.

// File: rtl/pwm_pacer_pkg.sv
package pwm_pacer_pkg;
  localparam int SAMPLE_W = 12;
  localparam int IRQ_FIELD_W = 4;
  localparam int IRQ_CNT_W = IRQ_FIELD_W + 1;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_LEFT   = 2'd2,
    SEL_RIGHT  = 2'd3
  } wr_sel_e;

  // field of 0 selects the maximum count
  function automatic logic [IRQ_CNT_W-1:0] irq_reload(input logic [IRQ_FIELD_W-1:0] f);
    return (f == '0) ? IRQ_CNT_W'(1 << IRQ_FIELD_W) : {1'b0, f};
  endfunction
endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int CYC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             period_we_i,
  input  logic [CYC_W-1:0] period_d_i,
  output logic             tick_o
);
  logic [CYC_W-1:0] period_q, cnt_q;

  assign tick_o = (period_q != '0) && (cnt_q == period_q - CYC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (period_we_i) begin
      period_q <= period_d_i;
      cnt_q    <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else if (period_q != '0) begin
      cnt_q <= cnt_q + CYC_W'(1);
    end
  end
endmodule

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && !full_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
      data_o <= '0;
    end else begin
      if (do_pop) begin
        data_o <= mem_q[rd_q];
        rd_q   <= nxt(rd_q);
      end
      if (do_push) wr_q <= nxt(wr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/pwm_irq_divider.sv
module pwm_irq_divider
  import pwm_pacer_pkg::*;
#(
  parameter int NUM_CONS = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   reload_we_i,
  input  logic [IRQ_FIELD_W-1:0] field_i,
  input  logic                   dreq_en_i,
  input  logic [NUM_CONS-1:0]    irq_en_i,
  input  logic                   irq_ack_i,
  output logic                   irq_o,
  output logic                   dreq_o
);
  logic [IRQ_CNT_W-1:0] cnt_q;
  logic [IRQ_CNT_W-1:0] reload_q;
  logic                 expire, raise;

  assign expire = tick_i && !reload_we_i && (cnt_q == IRQ_CNT_W'(1));
  assign raise  = expire && !irq_o && (|irq_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= irq_reload('0);
      reload_q <= irq_reload('0);
      irq_o    <= 1'b0;
      dreq_o   <= 1'b0;
    end else begin
      if (reload_we_i) begin
        reload_q <= irq_reload(field_i);
        cnt_q    <= irq_reload(field_i);
      end else if (expire) begin
        cnt_q <= reload_q;
      end else if (tick_i) begin
        cnt_q <= cnt_q - IRQ_CNT_W'(1);
      end
      irq_o  <= (irq_o && !irq_ack_i) || raise;
      dreq_o <= raise && dreq_en_i;
    end
  end
endmodule

// File: rtl/pwm_pacer.sv
module pwm_pacer
  import pwm_pacer_pkg::*;
#(
  parameter int CYC_W      = 12,
  parameter int FIFO_DEPTH = 3,
  parameter int NUM_CONS   = 2,
  parameter int DATA_W     = 16,
  parameter int DREQ_BIT   = 7,
  parameter int FIELD_LSB  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                irq_ack_i,
  input  logic [NUM_CONS-1:0] irq_en_i,
  output logic [SAMPLE_W-1:0] sample_l_o,
  output logic [SAMPLE_W-1:0] sample_r_o,
  output logic [1:0]          fifo_full_o,
  output logic [1:0]          fifo_empty_o,
  output logic                irq_o,
  output logic                dreq_o
);
  localparam int NCH = 2;

  logic                dreq_en_q;
  logic                tick;
  logic                ctrl_we, period_we;
  logic [NCH-1:0]      push;
  logic [SAMPLE_W-1:0] pw_val;
  logic [SAMPLE_W-1:0] ch_out [NCH];

  assign ctrl_we   = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign period_we = wr_en_i && (wr_sel_i == SEL_PERIOD);
  assign push[0]   = wr_en_i && (wr_sel_i == SEL_LEFT);
  assign push[1]   = wr_en_i && (wr_sel_i == SEL_RIGHT);
  assign pw_val    = wr_data_i[SAMPLE_W-1:0] - SAMPLE_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dreq_en_q <= 1'b0;
    else if (ctrl_we) dreq_en_q <= wr_data_i[DREQ_BIT];
  end

  pwm_period_timer #(.CYC_W(CYC_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_we_i (period_we),
    .period_d_i  (wr_data_i[CYC_W-1:0]),
    .tick_o      (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[c]),
      .data_i  (pw_val),
      .pop_i   (tick),
      .data_o  (ch_out[c]),
      .full_o  (fifo_full_o[c]),
      .empty_o (fifo_empty_o[c])
    );
  end

  assign sample_l_o = ch_out[0];
  assign sample_r_o = ch_out[1];

  pwm_irq_divider #(.NUM_CONS(NUM_CONS)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .reload_we_i (ctrl_we),
    .field_i     (wr_data_i[FIELD_LSB +: IRQ_FIELD_W]),
    .dreq_en_i   (dreq_en_q),
    .irq_en_i    (irq_en_i),
    .irq_ack_i   (irq_ack_i),
    .irq_o       (irq_o),
    .dreq_o      (dreq_o)
  );
endmodule

// File: rtl/pwm_pacer_chk.sv
module pwm_pacer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        irq_ack_i,
  input logic        irq_o,
  input logic        dreq_o,
  input logic [11:0] sample_l_o,
  input logic [11:0] sample_r_o
);
  // R9
  dreq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |=> !dreq_o);
  // R9
  dreq_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> (irq_o && !$past(irq_o)));
  // R7
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);
  // R7
  irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_ack_i) |=> !irq_o);
  // R5
  irq_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i));
  // R2
  left_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_l_o) |-> $past(tick_i));
  // R2
  right_on_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_r_o) |-> $past(tick_i));
endmodule

bind pwm_pacer pwm_pacer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick),
  .irq_ack_i  (irq_ack_i),
  .irq_o      (irq_o),
  .dreq_o     (dreq_o),
  .sample_l_o (sample_l_o),
  .sample_r_o (sample_r_o)
);

// File: tb/pwm_pacer_bench.sv
module pwm_pacer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic [1:0]  en = 2'b11;
  logic [11:0] s_l, s_r;
  logic [1:0]  full, empty;
  logic        irq, dreq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_pacer u_pwm_pacer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .irq_ack_i(ack), .irq_en_i(en),
    .sample_l_o(s_l), .sample_r_o(s_r), .fifo_full_o(full),
    .fifo_empty_o(empty), .irq_o(irq), .dreq_o(dreq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(posedge clk);
    #1 ack = 1'b0;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (!irq && k < 400);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 left", s_l, 0);
    chk("R10 right", s_r, 0);
    chk("R10 empty", empty, 3);
    chk("R10 full", full, 0);
    chk("R10 irq", irq, 0);
    chk("R10 dreq", dreq, 0);

    // R4 queue depth and drop, R2 value-1 storage
    wr(2, 16'd10); wr(2, 16'd20); wr(2, 16'd30);
    @(negedge clk);
    chk("R4 left full", full[0], 1);
    wr(2, 16'd40);
    wr(3, 16'd5);
    @(negedge clk);
    chk("R4 full flags", full, 2'b01);
    chk("R4 empty flags", empty, 2'b00);
    // R1 period 0 consumes nothing
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R1 zero period left", s_l, 0);
    chk("R1 zero period irq", irq, 0);

    // start period 2 (upper bits dropped): boundaries at +2,+4,+6,+8
    wr(1, 16'hF002);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 left first", s_l, 9);
    chk("R2 right first", s_r, 4);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 left second", s_l, 19);
    chk("R3 right hold", s_r, 4);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 left third", s_l, 29);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4 dropped write, R3 hold", s_l, 29);
    chk("R4 drained", empty, 2'b11);
    wr(2, 16'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 zero wraps", s_l, 12'hFFF);

    // R5/R9 sweep: field x period
    for (int fi = 0; fi < 4; fi++) begin
      for (int p = 1; p <= 3; p++) begin
        int f, n, rtp;
        f = (fi == 3) ? 0 : fi + 1;
        n = (f == 0) ? 16 : f;
        rtp = (fi + p) % 2;
        wr(1, 16'd0);
        do_ack();
        wr(0, 16'((f << 8) | (rtp << 7)));
        wr(1, 16'(p));
        wait_irq(k);
        chk($sformatf("R5 f=%0d p=%0d", f, p), k, n * p);
        chk("R9 dreq with irq", dreq, rtp);
        @(negedge clk);
        chk("R9 dreq one clock", dreq, 0);
      end
    end

    // R7 hold and ack
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R7 hold", irq, 1);

    // R6 restart: field 3, period 2
    wr(1, 16'd0);
    do_ack();
    @(negedge clk);
    chk("R7 cleared", irq, 0);
    wr(0, 16'h0300);
    wr(1, 16'd2);
    @(posedge clk); @(posedge clk);
    wr(0, 16'h0300);
    wait_irq(k);
    chk("R6 restart count", k, 5);

    // R8 pending blocks further raises
    wr(1, 16'd0);
    do_ack();
    wr(0, 16'h0180);
    wr(1, 16'd2);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (dreq) cnt++;
    end
    chk("R8 one raise while pending", cnt, 1);
    do_ack();
    wait_irq(k);
    chk("R8 next after ack", (k <= 2) ? 1 : 0, 1);

    // R8 all masked
    en = 2'b00;
    do_ack();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq || dreq) cnt++;
    end
    chk("R8 masked", cnt, 0);
    en = 2'b10;
    wait_irq(k);
    chk("R8 single consumer", (k <= 2) ? 1 : 0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule